// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers the event sources of an audio codec: gain-down done, gain-up done, output ramp-down done, output ramp-up done, short-circuit detect and a change on the jack-detect line. It turns them into one interrupt line. Each event sets a sticky flag. Software reads the flags and clears them by writing 1s. A mask register blocks chosen sources from the interrupt line. Two high bits of the same register pick one of four output forms: a high level, a low level, a high pulse or a low pulse.

The five internal sources arrive as single-cycle pulses. The jack input is a level that has already been debounced. A change on the jack input in either direction latches an event flag. The present jack state can also be read next to that flag. A small state machine drives the output line. Its states are ST_IDLE (nothing pending), ST_LEVEL (level form, a source pending), ST_PULSE (pulse being driven, counted for PULSE_LEN cycles) and ST_HOLD (pulse finished, waiting for the pending set to empty). The transitions are:
- ST_IDLE to ST_LEVEL: a source is pending and the form is a level.
- ST_IDLE to ST_PULSE: a source is pending and the form is a pulse.
- ST_LEVEL to ST_IDLE: nothing is pending.
- ST_PULSE to ST_HOLD: the pulse count has expired.
- ST_HOLD to ST_IDLE: nothing is pending.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the flag read value is 0x00 apart from bit 6, which follows the jack input. The mask read value is 0x3F, which masks every source and selects form 00. The interrupt line is low.
- R2: The event pulse input bits land on flag bits in this order: bit 0 gain-down done, bit 1 gain-up done, bit 2 ramp-down done, bit 3 ramp-up done, bit 4 short-circuit. A pulse sets its flag on the next clock edge whatever the mask holds.
- R3: Every change of the jack input, rising or falling, sets flag bit 5 on the next edge. Flag bit 6 reads the jack level as sampled on the last edge. Writes to bit 6 have no effect.
- R4: A flag write clears each flag bit 5:0 whose data bit is 1 and leaves every bit whose data bit is 0 unchanged. The value 0x3F clears all six.
- R5: When an event and a clear of the same flag occur in the same cycle, the flag stays set.
- R6: A mask write stores all 8 bits, which read back unchanged. Mask bits 5:0 use the flag positions. A set mask bit keeps its source out of the interrupt line, and a cleared bit lets it through.
- R7: Mask bits 7:6 = 00 gives an active-high level. The line goes high one cycle after an unmasked flag is seen set and goes low one cycle after no unmasked flag remains.
- R8: Mask bits 7:6 = 01 gives the same timing as R7 with the line active low.
- R9: Mask bits 7:6 = 10 gives a high pulse of exactly PULSE_LEN cycles, starting one cycle after an unmasked flag is seen set. No further pulse is produced until the set of unmasked flags has been empty for at least one cycle.
- R10: Mask bits 7:6 = 11 gives the pulse of R9 with the line active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 5 | Single-cycle event pulses, bit positions as in R2 |
| jack_lvl | input | 1 | Debounced jack-detect level |
| flag_wr | input | 1 | Write strobe for the flag register (write 1 to clear) |
| mask_wr | input | 1 | Write strobe for the mask register |
| wr_data | input | 8 | Write data shared by both registers |
| flag_rd | output | 8 | Flags in bits 5:0, live jack state in bit 6, bit 7 zero |
| mask_rd | output | 8 | Mask read value |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench targets the cycle where an event pulse meets a write-1-to-clear of the same bit. A design that lets the clear win would lose that event. It also checks that a falling jack edge raises the event flag as well as a rising one; a design that watches only insertion would miss removal. In the pulse forms the bench counts the active cycles exactly and then holds a flag pending. A design that counts off by one, or that re-fires while the flag is still set, shows up there. Masking is tested both by raising a masked source with the line expected to stay idle and by unmasking an already pending flag, which must raise the line.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;

    localparam int NUM_SRC  = 5;
    localparam int FLAG_W   = 6;
    localparam int REG_W    = 8;
    localparam int JACK_EVT = 5;
    localparam int JACK_LVL = 6;

    typedef enum logic [1:0] {
        FORM_HI_LEVEL = 2'b00,
        FORM_LO_LEVEL = 2'b01,
        FORM_HI_PULSE = 2'b10,
        FORM_LO_PULSE = 2'b11
    } irq_form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEVEL,
        ST_PULSE,
        ST_HOLD
    } irq_state_e;

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import codec_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK_RST = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_pulse,
    input  logic                 jack_lvl,
    input  logic                 flag_wr,
    input  logic                 mask_wr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     flag_rd,
    output logic [REG_W-1:0]     mask_rd,
    output logic                 pending,
    output irq_form_e            form
);

    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [REG_W-1:0]  mask_q;
    logic              jack_q;

    // Source vector: five pulses plus the jack edge
    always_comb begin
        set_vec = '0;
        set_vec[NUM_SRC-1:0] = src_pulse;
        set_vec[JACK_EVT]    = jack_lvl ^ jack_q;
        clr_vec = flag_wr ? wr_data[FLAG_W-1:0] : '0;
    end

    // Set wins over clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            jack_q  <= 1'b0;
            mask_q  <= MASK_RST;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            jack_q  <= jack_lvl;
            if (mask_wr)
                mask_q <= wr_data;
        end
    end

    always_comb begin
        flag_rd           = '0;
        flag_rd[FLAG_W-1:0] = flags_q;
        flag_rd[JACK_LVL] = jack_q;
        mask_rd           = mask_q;
        pending           = |(flags_q & ~mask_q[FLAG_W-1:0]);
        form              = irq_form_e'(mask_q[REG_W-1:REG_W-2]);
    end

    // R4: without a flag write no set flag may drop
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R2: every pulse lands in its flag on the next edge
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((flags_q[NUM_SRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

    // R5: a clear in the same cycle as an event does not win
    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && (|(wr_data[NUM_SRC-1:0] & src_pulse)))
        |=> (|(flags_q[NUM_SRC-1:0] & $past(src_pulse))));

    // R3: the jack state bit trails the input by one edge
    p_jack_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_rd[JACK_LVL] == $past(jack_lvl)));

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import codec_irq_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pending,
    input  irq_form_e form,
    output logic      irq
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             is_pulse;

    assign is_pulse = form[1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pending) state_d = is_pulse ? ST_PULSE : ST_LEVEL;
            ST_LEVEL: if (!pending) state_d = ST_IDLE;
            ST_PULSE: if (cnt_q == CNT_LAST) state_d = ST_HOLD;
            ST_HOLD:  if (!pending) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_PULSE) ? cnt_q + 1'b1 : '0;
        end
    end

    // Output: asserted in ST_LEVEL/ST_PULSE, polarity from form bit 0
    always_comb begin
        logic active;
        active = (state_q == ST_LEVEL) || (state_q == ST_PULSE);
        irq    = active ^ form[0];
    end

    // R9: the pulse counter never passes its limit
    p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> (cnt_q <= CNT_LAST));

    // R9: after the pulse, no return to idle while still pending
    p_hold_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && pending) |=> (state_q == ST_HOLD));

    // R6: nothing pending keeps the machine idle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pending) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
    import codec_irq_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               jack_lvl,
    input  logic               flag_wr,
    input  logic               mask_wr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   flag_rd,
    output logic [REG_W-1:0]   mask_rd,
    output logic               irq
);

    logic      pending;
    irq_form_e form;

    irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .jack_lvl  (jack_lvl),
        .flag_wr   (flag_wr),
        .mask_wr   (mask_wr),
        .wr_data   (wr_data),
        .flag_rd   (flag_rd),
        .mask_rd   (mask_rd),
        .pending   (pending),
        .form      (form)
    );

    irq_out_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .form    (form),
        .irq     (irq)
    );

    // R7: in the high level form, a pending source shows on the line one edge later
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd[7:6] == 2'b00 && pending && !mask_wr) |=> irq);

endmodule

// File: tb/codec_irq_unit_bench.sv
module codec_irq_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PLEN       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_pulse = '0;
    logic       jack_lvl = 1'b0;
    logic       flag_wr = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] flag_rd, mask_rd;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_irq_unit #(.PULSE_LEN(PLEN)) u_codec_irq_unit (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .jack_lvl(jack_lvl),
        .flag_wr(flag_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .flag_rd(flag_rd), .mask_rd(mask_rd), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All stimulus is driven and sampled at the falling edge
    task automatic step();
        @(negedge clk);
        src_pulse = '0; flag_wr = 1'b0; mask_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_wr = 1'b1; wr_data = v; step();
    endtask

    task automatic wr_flag(input logic [7:0] v);
        flag_wr = 1'b1; wr_data = v; step();
    endtask

    task automatic t_reset();
        chk("R1 flags", flag_rd, 8'h00);
        chk("R1 mask", mask_rd, 8'h3F);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_sources();
        for (int i = 0; i < 5; i++) begin
            src_pulse = 5'(1 << i); step();
            chk("R2 flag position", flag_rd, 8'((1 << (i + 1)) - 1));
        end
        step();
        chk("R6 masked irq idle", {7'd0, irq}, 8'h00);
        wr_flag(8'h3F);
        chk("R4 clear all", flag_rd, 8'h00);
    endtask

    task automatic t_clear();
        src_pulse = 5'h1F; step();
        wr_flag(8'h05);
        chk("R4 partial clear", flag_rd, 8'h1A);
        wr_flag(8'h40);
        chk("R4 bit6 write ignored", flag_rd, 8'h1A);
        wr_flag(8'h3F);
        chk("R4 clear rest", flag_rd, 8'h00);
    endtask

    task automatic t_collide();
        src_pulse = 5'h08; flag_wr = 1'b1; wr_data = 8'h08; step();
        chk("R5 event beats clear", flag_rd, 8'h08);
        wr_flag(8'h3F);
    endtask

    task automatic t_jack();
        jack_lvl = 1'b1; step();
        chk("R3 rise sets evt", flag_rd, 8'h60);
        wr_flag(8'h20);
        chk("R3 live level kept", flag_rd, 8'h40);
        jack_lvl = 1'b0; step();
        chk("R3 fall sets evt", flag_rd, 8'h20);
        wr_flag(8'h3F);
    endtask

    task automatic t_level(input logic low, input string tag);
        logic idle_v;
        idle_v = low;
        wr_mask({1'b0, low, 6'h3E});
        chk({tag, " mask readback"}, mask_rd, {1'b0, low, 6'h3E});
        src_pulse = 5'h02; step();
        chk({tag, " masked src idle"}, {7'd0, irq}, {7'd0, idle_v});
        src_pulse = 5'h01; step();
        chk({tag, " not yet"}, {7'd0, irq}, {7'd0, idle_v});
        step();
        chk({tag, " active"}, {7'd0, irq}, {7'd0, ~idle_v});
        wr_flag(8'h01);
        chk({tag, " still active"}, {7'd0, irq}, {7'd0, ~idle_v});
        step();
        chk({tag, " released"}, {7'd0, irq}, {7'd0, idle_v});
        wr_mask({1'b0, low, 6'h3C});
        step();
        chk({tag, " R6 unmask pending"}, {7'd0, irq}, {7'd0, ~idle_v});
        wr_flag(8'h3F);
        step();
        wr_mask(8'h3F);
    endtask

    task automatic t_pulse(input logic low, input string tag);
        int act_cnt;
        wr_mask({1'b1, low, 6'h2F});
        src_pulse = 5'h10; step();
        chk({tag, " flag"}, flag_rd, 8'h10);
        act_cnt = 0;
        for (int k = 0; k < PLEN + 6; k++) begin
            step();
            if (irq != low) act_cnt++;
        end
        chk({tag, " pulse length"}, 8'(act_cnt), 8'(PLEN));
        wr_flag(8'h10);
        step();
        src_pulse = 5'h10; step();
        step();
        chk({tag, " rearm"}, {7'd0, irq}, {7'd0, ~low});
        wr_flag(8'h3F);
        for (int k = 0; k < PLEN + 2; k++) step();
        chk({tag, " rest"}, {7'd0, irq}, {7'd0, low});
        wr_mask(8'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_sources();
        t_clear();
        t_collide();
        t_jack();
        t_level(1'b0, "R7");
        t_level(1'b1, "R8");
        t_pulse(1'b0, "R9");
        t_pulse(1'b1, "R10");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule